// File: doc/BRIEF.md
# Serial EEPROM Page-Write Slave

This block is the write side of a byte-addressed nonvolatile memory that listens on a two-wire serial bus. It watches the clock and data lines and finds START and STOP conditions. After a START it takes a device byte, a high and a low word address byte, and any number of data bytes. It acknowledges each accepted byte. The data bytes go into a page buffer whose pointer wraps inside one page. On the closing STOP the block runs a timed commit. The commit copies the buffered bytes into a behavioural memory array, and the block does not answer the bus until the commit ends.

The block only ever pulls SDA low; an external pull-up provides the high level. A flat read-side port exposes the array contents to the neighbouring read logic. The page size, the array size, the select bits and the commit length are parameters. The commit length must be at least the page size in bytes.

Top module: `page_write_slave`

## Requirements
- R1: After reset `busy` is low, SDA is not pulled low, and every array location reads zero.
- R2: Bits arrive MSB first. Only the device byte 1010, 0, S1, S0, 0 is acknowledged, where S1 and S0 come from `SEL_BITS` and the last bit (R/W) is 0. Any other device byte, including R/W = 1, gets no ACK. The rest of that transaction is then ignored and leaves the array unchanged.
- R3: After an accepted device byte, both word address bytes and every data byte are acknowledged. An ACK is SDA held low across the high phase of the ninth SCL clock of the byte.
- R4: The word address is 15 bits: bits 6..0 of the first address byte form bits 14..8, and the second byte forms bits 7..0. Bit 7 of the first byte is ignored. The array location is taken from the low `MEM_AW` bits.
- R5: Each data byte goes to the current offset in the page, and then only the low `PAGE_AW` address bits advance. A full page of bytes that starts at any offset fills the page in wrap order.
- R6: Data bytes beyond one page overwrite the earlier bytes in the same wrap order, so the last byte written to each offset wins.
- R7: A commit writes only the offsets that were loaded in the transaction. Every other location keeps its old contents.
- R8: A commit starts only at a STOP that follows at least one complete data byte. A STOP before any data byte leaves `busy` low and the array unchanged.
- R9: A START in the middle of a transaction, including one after data bytes, discards the buffered bytes without a commit and restarts decoding at the device byte.
- R10: `busy` stays high for exactly `COMMIT_CYCLES` clock cycles per commit.
- R11: While `busy` is high the block sends no ACK and ignores all bus activity. After `busy` falls, the next START is served normally.
- R12: Committed bytes are readable on `peekData` once `busy` has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaPullLow | output | 1 | High to pull SDA low (open-drain drive) |
| busy | output | 1 | High while the internal commit runs |
| peekAddr | input | MEM_AW | Array location for the read side |
| peekData | output | 8 | Contents of the array at `peekAddr` |

## Verification
The bench builds the block with 8-byte pages, a 64-byte array, select bits 10 and a 300-cycle commit. Small pages let the bench run every start offset, with single-byte, full-page and over-page loads, while a model of the whole array is checked after each commit. The 64-byte array can be read back in full each time. The 300-cycle commit is long enough to send a complete device byte while `busy` is high. All 256 device byte values are also tried, one by one, against the single accepted pattern.

// File: rtl/pw_pkg.sv
package pw_pkg;

  localparam int WORD_AW = 15;
  localparam logic [3:0] DEV_FAMILY = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WHI,
    ST_WLO,
    ST_DATA,
    ST_COMMIT
  } pwState_e;

  typedef struct packed {
    logic rxBit;
    logic shiftBit;
    logic loadHi;
    logic loadLo;
    logic storeData;
    logic clearMask;
    logic commitRun;
  } pwStrobe_t;

endpackage

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
#(
  parameter logic [1:0] SEL_BITS = 2'b00,
  parameter int COMMIT_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  output pwStrobe_t  strobe,
  output logic       sdaPullLow,
  output logic       busy
);

  localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] BUSY_LAST = CNT_W'(COMMIT_CYCLES - 1);
  localparam logic [7:0] DEV_WRITE = {DEV_FAMILY, 1'b0, SEL_BITS, 1'b0};

  logic [2:0] sclSync, sdaSync;
  logic sclNow, sclOld, sdaNow, sdaOld;
  logic sclRise, sclFall, startSeen, stopSeen;
  logic byteDone, active;
  pwState_e state;
  logic [3:0] bitCnt;
  logic ackWanted, dataSeen;
  logic [CNT_W-1:0] busyCnt;

  // two-stage synchroniser plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync <= {sclSync[1:0], sclIn};
      sdaSync <= {sdaSync[1:0], sdaIn};
    end
  end

  assign sclNow    = sclSync[1];
  assign sclOld    = sclSync[2];
  assign sdaNow    = sdaSync[1];
  assign sdaOld    = sdaSync[2];
  assign sclRise   = sclNow & ~sclOld;
  assign sclFall   = ~sclNow & sclOld;
  assign startSeen = sclNow & sclOld & sdaOld & ~sdaNow;
  assign stopSeen  = sclNow & sclOld & ~sdaOld & sdaNow;

  assign active   = state inside {ST_DEV, ST_WHI, ST_WLO, ST_DATA};
  assign byteDone = active && sclRise && (bitCnt == 4'd7);
  assign busy     = (state == ST_COMMIT);

  always_comb begin
    strobe.rxBit     = sdaNow;
    strobe.shiftBit  = active && sclRise && (bitCnt < 4'd8);
    strobe.loadHi    = byteDone && (state == ST_WHI);
    strobe.loadLo    = byteDone && (state == ST_WLO);
    strobe.storeData = byteDone && (state == ST_DATA);
    strobe.clearMask = startSeen && (state != ST_COMMIT);
    strobe.commitRun = (state == ST_COMMIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      ackWanted  <= 1'b0;
      dataSeen   <= 1'b0;
      busyCnt    <= '0;
      sdaPullLow <= 1'b0;
    end else if (state == ST_COMMIT) begin
      sdaPullLow <= 1'b0;
      if (busyCnt == BUSY_LAST) begin
        state   <= ST_IDLE;
        busyCnt <= '0;
      end else begin
        busyCnt <= busyCnt + 1'b1;
      end
    end else if (startSeen) begin
      state      <= ST_DEV;
      bitCnt     <= '0;
      ackWanted  <= 1'b0;
      dataSeen   <= 1'b0;
      sdaPullLow <= 1'b0;
    end else if (stopSeen) begin
      sdaPullLow <= 1'b0;
      ackWanted  <= 1'b0;
      state      <= (state == ST_DATA && dataSeen) ? ST_COMMIT : ST_IDLE;
    end else if (active) begin
      if (sclRise) begin
        bitCnt <= (bitCnt == 4'd8) ? 4'd0 : bitCnt + 4'd1;
        if (bitCnt == 4'd7) begin
          case (state)
            ST_DEV: begin
              ackWanted <= (rxByte == DEV_WRITE);
              state     <= (rxByte == DEV_WRITE) ? ST_WHI : ST_IDLE;
            end
            ST_WHI:  begin ackWanted <= 1'b1; state <= ST_WLO;  end
            ST_WLO:  begin ackWanted <= 1'b1; state <= ST_DATA; end
            ST_DATA: begin ackWanted <= 1'b1; dataSeen <= 1'b1; end
            default: ackWanted <= 1'b0;
          endcase
        end
      end
      if (sclFall) sdaPullLow <= (bitCnt == 4'd8) && ackWanted;
    end
  end

  // R11
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaPullLow);

  // R10
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(busyCnt) == BUSY_LAST);

  // R8
  commit_needs_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(dataSeen));

  // R3
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdaPullLow |-> (bitCnt == 4'd8 || bitCnt == 4'd0));

endmodule

// File: rtl/pw_datapath.sv
module pw_datapath
  import pw_pkg::*;
#(
  parameter int PAGE_AW = 6,
  parameter int MEM_AW  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwStrobe_t         strobe,
  input  logic [MEM_AW-1:0] peekAddr,
  output logic [7:0]        rxByte,
  output logic [7:0]        peekData
);

  localparam int PAGE_BYTES = 1 << PAGE_AW;
  localparam int MEM_BYTES  = 1 << MEM_AW;

  logic [6:0] shiftReg;
  logic [WORD_AW-1:0] wordAddr;
  logic [PAGE_AW-1:0] slot;
  logic [7:0] pageLatch [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loadedMask;
  logic [PAGE_AW:0] sweepIdx;
  logic [WORD_AW-1:0] sweepAddr;
  logic [MEM_AW-1:0] memIdx;
  logic sweepWrite;
  logic [7:0] memArray [MEM_BYTES];

  assign rxByte     = {shiftReg, strobe.rxBit};
  assign slot       = wordAddr[PAGE_AW-1:0];
  assign sweepAddr  = {wordAddr[WORD_AW-1:PAGE_AW], sweepIdx[PAGE_AW-1:0]};
  assign memIdx     = MEM_AW'(sweepAddr);
  assign sweepWrite = strobe.commitRun && !sweepIdx[PAGE_AW]
                      && loadedMask[sweepIdx[PAGE_AW-1:0]];
  assign peekData   = memArray[peekAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      wordAddr   <= '0;
      loadedMask <= '0;
      sweepIdx   <= '0;
    end else begin
      if (strobe.shiftBit) shiftReg <= rxByte[6:0];
      if (strobe.loadHi) wordAddr[WORD_AW-1:8] <= rxByte[6:0];
      if (strobe.loadLo) wordAddr[7:0] <= rxByte;
      if (strobe.storeData) begin
        wordAddr[PAGE_AW-1:0] <= slot + 1'b1;
        loadedMask[slot]      <= 1'b1;
      end
      if (strobe.clearMask) loadedMask <= '0;
      if (!strobe.commitRun) sweepIdx <= '0;
      else if (!sweepIdx[PAGE_AW]) sweepIdx <= sweepIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.storeData) pageLatch[slot] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) memArray[i] <= '0;
    end else if (sweepWrite) begin
      memArray[memIdx] <= pageLatch[sweepIdx[PAGE_AW-1:0]];
    end
  end

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeData |=> $stable(wordAddr[WORD_AW-1:PAGE_AW]));

  // R4
  load_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadHi, strobe.loadLo, strobe.storeData}));

endmodule

// File: rtl/page_write_slave.sv
module page_write_slave
  import pw_pkg::*;
#(
  parameter logic [1:0] SEL_BITS = 2'b00,
  parameter int PAGE_AW = 6,
  parameter int MEM_AW = 11,
  parameter int COMMIT_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  output logic              busy,
  input  logic [MEM_AW-1:0] peekAddr,
  output logic [7:0]        peekData
);

  pwStrobe_t strobe;
  logic [7:0] rxByte;

  pw_ctrl #(
    .SEL_BITS(SEL_BITS),
    .COMMIT_CYCLES(COMMIT_CYCLES)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .rxByte(rxByte),
    .strobe(strobe),
    .sdaPullLow(sdaPullLow),
    .busy(busy)
  );

  pw_datapath #(
    .PAGE_AW(PAGE_AW),
    .MEM_AW(MEM_AW)
  ) u_datapath (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .peekAddr(peekAddr),
    .rxByte(rxByte),
    .peekData(peekData)
  );

endmodule

// File: tb/page_write_slave_bench.sv
module page_write_slave_bench;

  localparam int H = 5;
  localparam int PAGE_AW = 3;
  localparam int MEM_AW = 6;
  localparam int COMMIT = 300;
  localparam int PB = 1 << PAGE_AW;
  localparam int MB = 1 << MEM_AW;
  localparam logic [7:0] DEV_OK = 8'hA4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLine;
  logic sdaPullLow, busy;
  logic [MEM_AW-1:0] peekAddr = '0;
  logic [7:0] peekData;

  int errors = 0;
  int checks = 0;
  logic [7:0] expMem [MB];
  logic [7:0] lat [PB];
  bit latValid [PB];
  int busyRun = 0;
  int lastBusyLen = 0;
  int commitCount = 0;
  logic busyPrev = 1'b0;

  assign sdaLine = sdaM & ~sdaPullLow;

  always #5 clk = ~clk;

  page_write_slave #(
    .SEL_BITS(2'b10),
    .PAGE_AW(PAGE_AW),
    .MEM_AW(MEM_AW),
    .COMMIT_CYCLES(COMMIT)
  ) u_page_write_slave (
    .clk(clk),
    .rstN(rstN),
    .sclIn(scl),
    .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow),
    .busy(busy),
    .peekAddr(peekAddr),
    .peekData(peekData)
  );

  always @(negedge clk) begin
    if (busy && !busyPrev) begin
      commitCount++;
      busyRun = 1;
    end else if (busy) begin
      busyRun++;
    end else if (busyPrev) begin
      lastBusyLen = busyRun;
    end
    busyPrev = busy;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(H);
    scl = 1'b1;  tick(H);
    sdaM = 1'b0; tick(H);
    scl = 1'b0;  tick(2);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(H);
    scl = 1'b1;  tick(H);
    sdaM = 1'b1; tick(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; tick(H);
      scl = 1'b1;  tick(H);
      scl = 1'b0;  tick(2);
    end
    sdaM = 1'b1; tick(H);
    scl = 1'b1;  tick(2);
    acked = !sdaLine;
    tick(H - 2);
    scl = 1'b0;  tick(2);
  endtask

  task automatic waitIdle();
    tick(6);
    for (int g = 0; g < 2000 && busy; g++) tick(1);
    tick(3);
  endtask

  task automatic compareMem(input string req);
    int bad;
    int firstAct;
    int firstExp;
    bad = 0; firstAct = 0; firstExp = 0;
    for (int a = 0; a < MB; a++) begin
      peekAddr = MEM_AW'(a);
      tick(1);
      if (peekData !== expMem[a]) begin
        if (bad == 0) begin
          firstAct = int'(peekData);
          firstExp = int'(expMem[a]);
        end
        bad++;
      end
    end
    check(bad == 0, req, firstAct, firstExp);
  endtask

  // open a write to word address {hi,lo} and send n data bytes, tracking the page buffer
  task automatic txnBody(input logic [7:0] hi, input logic [7:0] lo, input int n,
                         input int seed, input string req);
    logic a;
    for (int i = 0; i < PB; i++) latValid[i] = 1'b0;
    busStart();
    sendByte(DEV_OK, a); check(a === 1'b1, "R3 device byte ack", int'(a), 1);
    sendByte(hi, a);     check(a === 1'b1, "R3 high address ack", int'(a), 1);
    sendByte(lo, a);     check(a === 1'b1, "R3 low address ack", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      int idx;
      d = 8'(seed * 29 + k * 7 + 3);
      idx = (int'(lo) + k) % PB;
      sendByte(d, a);
      check(a === 1'b1, req, int'(a), 1);
      lat[idx] = d;
      latValid[idx] = 1'b1;
    end
  endtask

  task automatic commitModel(input logic [7:0] lo);
    int base;
    base = (int'(lo) % MB) / PB * PB;
    for (int i = 0; i < PB; i++)
      if (latValid[i]) expMem[base + i] = lat[i];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c0;
    logic a;
    for (int i = 0; i < MB; i++) expMem[i] = 8'h00;
    tick(4);
    rstN = 1'b1;
    tick(4);
    // R1
    check(busy === 1'b0, "R1 busy low after reset", int'(busy), 0);
    check(sdaPullLow === 1'b0, "R1 SDA released after reset", int'(sdaPullLow), 0);
    compareMem("R1 array clear after reset");

    // R2: every device byte value, only one is acknowledged
    for (int b = 0; b < 256; b++) begin
      logic ak;
      busStart();
      sendByte(8'(b), ak);
      busStop();
      tick(2);
      check(ak === (8'(b) == DEV_OK), "R2 device byte decode",
            int'(ak), int'(8'(b) == DEV_OK));
    end
    // R8: address-only transactions never commit
    check(commitCount == 0, "R8 no commit without data", commitCount, 0);
    check(busy === 1'b0, "R8 busy low without data", int'(busy), 0);

    // R5 R6 R7 R4 R12 R10: every start offset, three load lengths
    for (int off = 0; off < PB; off++) begin
      for (int ni = 0; ni < 3; ni++) begin
        int n;
        int pg;
        logic [7:0] hi;
        logic [7:0] lo;
        string req;
        n = (ni == 0) ? 1 : ((ni == 1) ? PB : PB + 3);
        pg = (off * 3 + ni) % (MB / PB);
        lo = 8'(128 + pg * PB + off);
        hi = 8'(128 + off * 16 + ni);
        req = (ni == 0) ? "R7 single byte keeps rest of page (R4 R12)" :
              ((ni == 1) ? "R5 full page wraps in page (R4 R12)" :
                           "R6 overflow overwrites in wrap order (R4 R12)");
        c0 = commitCount;
        txnBody(hi, lo, n, off * 3 + ni + 1, req);
        busStop();
        waitIdle();
        check(commitCount == c0 + 1, "R8 commit after data and STOP", commitCount, c0 + 1);
        check(lastBusyLen == COMMIT, "R10 busy length", lastBusyLen, COMMIT);
        commitModel(lo);
        compareMem(req);
      end
    end

    // R2: wrong select bits, whole write ignored
    c0 = commitCount;
    busStart();
    sendByte(8'hA6, a); check(a === 1'b0, "R2 wrong select not acked", int'(a), 0);
    sendByte(8'h00, a); check(a === 1'b0, "R2 later bytes not acked", int'(a), 0);
    sendByte(8'h10, a);
    sendByte(8'h5A, a);
    busStop();
    tick(10);
    check(commitCount == c0, "R2 no commit after wrong select", commitCount, c0);
    compareMem("R2 array unchanged after wrong select");

    // R8: STOP right after the word address
    busStart();
    sendByte(DEV_OK, a);
    sendByte(8'h00, a);
    sendByte(8'h09, a);
    busStop();
    tick(10);
    check(commitCount == c0, "R8 STOP before data", commitCount, c0);
    check(busy === 1'b0, "R8 busy stays low", int'(busy), 0);

    // R9: repeated START after data discards the buffer
    txnBody(8'h00, 8'(128 + 2 * PB + 6), 2, 77, "R9 data before repeated START");
    txnBody(8'h00, 8'(64 + 5 * PB + 1), 1, 91, "R9 decode restarts after START");
    busStop();
    waitIdle();
    check(commitCount == c0 + 1, "R9 one commit only", commitCount, c0 + 1);
    commitModel(8'(64 + 5 * PB + 1));
    compareMem("R9 only bytes after repeated START land");

    // R11: bus activity during the commit is ignored
    c0 = commitCount;
    txnBody(8'h00, 8'(PB + 2), 3, 55, "R11 data before lockout");
    busStop();
    tick(4);
    check(busy === 1'b1, "R11 busy after STOP", int'(busy), 1);
    busStart();
    sendByte(DEV_OK, a);
    check(a === 1'b0, "R11 no ACK while busy", int'(a), 0);
    busStop();
    check(busy === 1'b1, "R11 still busy after bus traffic", int'(busy), 1);
    waitIdle();
    check(commitCount == c0 + 1, "R11 no extra commit", commitCount, c0 + 1);
    check(lastBusyLen == COMMIT, "R10 R11 busy length unchanged by traffic", lastBusyLen, COMMIT);
    commitModel(8'(PB + 2));
    compareMem("R11 array after locked commit");
    txnBody(8'h7F, 8'(7 * PB + 7), 2, 13, "R11 served again after busy");
    busStop();
    waitIdle();
    commitModel(8'(7 * PB + 7));
    compareMem("R11 R12 write after lockout");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule